// File: doc/BRIEF.md
# Three-Digit Decimal Millisecond Stopwatch

This block is a stopwatch that keeps a count of milliseconds in three binary coded decimal digits, so the count runs from 000 to 999 and then wraps. A prescaler divides the system clock by `CLK_DIV` to produce a 1 kHz increment tick. With the default of 32 and a 32 kHz system clock, this gives one increment per millisecond.

The counting gate has three sources, picked by `mode_i`:

- **Software level:** counting follows a software run bit.
- **Pulse width:** counting follows the level of a measurement pin.
- **Period:** a rising edge on the pin clears the count and starts it, and the next rising edge stops it.

In period mode the held digits are the time between the two rising edges. A software clear zeroes the digits at any time.

An interrupt pulse marks each tenth of a second or each full second, chosen by `irq_sel_i`. The measurement pin is expected to arrive already synchronous and debounced.

Top module: `bcd_ms_counter`

## Requirements
- R1: `digits_o[3:0]` holds the ones digit, `[7:4]` the tens digit and `[11:8]` the hundreds digit. Each digit is always in the range 0 to 9.
- R2: While `running_o` is high, the count rises by one every `CLK_DIV` clock cycles. The first increment comes on the `CLK_DIV`-th clock edge after `running_o` rises. The prescaler restarts from zero whenever counting is stopped.
- R3: A ones digit at 9 wraps to 0 and carries into the tens digit. The tens digit carries into the hundreds digit in the same way. The count 999 wraps to 000.
- R4: With `mode_i` = 0 (software), `running_o` takes the value of `sw_run_i` one cycle later.
- R5: With `mode_i` = 1 (pulse width), `running_o` takes the value of `meas_pin_i` one cycle later.
- R6: With `mode_i` = 2 (period), a rising edge of `meas_pin_i` while stopped clears the digits and starts counting. The next rising edge stops counting and leaves the measured value. With `mode_i` = 3, counting is stopped.
- R7: A high `clear_i` sets the digits to 000 and restarts the prescaler on the next cycle. It overrides an increment in that cycle and suppresses any interrupt from that increment. It does not change `running_o`.
- R8: With `irq_sel_i` = 0, `irq_o` pulses high for one cycle whenever the lower two digits wrap from 99 to 00. The pulse appears in the same cycle as the new digits.
- R9: With `irq_sel_i` = 1, `irq_o` pulses only when the count wraps from 999 to 000.
- R10: After reset, the digits are 000, and both `running_o` and `irq_o` are low.
- R11: While `running_o` is low and no clear occurs, the digits hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Selects the run source: 0 software, 1 pulse width, 2 period, 3 stopped |
| sw_run_i | input | 1 | Software run level, used in mode 0 |
| meas_pin_i | input | 1 | Synchronous, debounced measurement pin |
| clear_i | input | 1 | Synchronous clear of the digits and the prescaler |
| irq_sel_i | input | 1 | Interrupt rate: 0 for every 0.1 s, 1 for every 1 s |
| digits_o | output | 12 | Three BCD digits; the hundreds digit is in the top nibble |
| running_o | output | 1 | High while counting is enabled |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
A corrupted prescaler count moves the next increment away from its cycle. This shows up as a digit mismatch within `CLK_DIV` cycles of a run start.

A wrong digit register or carry shows up at the first increment that touches that digit. Examples are a tens digit left at 10, or a carry that goes missing at 099. An error in the run-state register appears on `running_o` the cycle after the gate input changes. In period mode it also appears as a wrong held value after the stopping edge.

An error in interrupt qualification shows as a pulse at a count whose lower digits are not 00. It also shows as a missing pulse at 100 or at 000.

// File: rtl/bcd_ms_pkg.sv
package bcd_ms_pkg;
  typedef enum logic [1:0] {
    MODE_SW     = 2'd0,
    MODE_WIDTH  = 2'd1,
    MODE_PERIOD = 2'd2,
    MODE_OFF    = 2'd3
  } run_mode_e;
endpackage

// File: rtl/bcd_ms_run_ctrl.sv
module bcd_ms_run_ctrl
  import bcd_ms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       sw_run_i,
  input  logic       pin_i,
  output logic       run_o,
  output logic       start_clr_o
);
  logic pin_q, run_q, run_d, rise;
  run_mode_e mode;

  assign mode = run_mode_e'(mode_i);
  assign rise = pin_i & ~pin_q;

  always_comb begin
    unique case (mode)
      MODE_SW:     run_d = sw_run_i;
      MODE_WIDTH:  run_d = pin_i;
      MODE_PERIOD: run_d = rise ? ~run_q : run_q;
      default:     run_d = 1'b0;
    endcase
  end

  // A period measurement starts from zero.
  assign start_clr_o = (mode == MODE_PERIOD) && rise && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      run_q <= run_d;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/bcd_ms_prescaler.sv
module bcd_ms_prescaler #(
  parameter int unsigned CLK_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i || !run_i)      cnt_q <= '0;
    else if (cnt_q == LAST)        cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcd_ms_digit.sv
module bcd_ms_digit (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       inc_i,
  output logic [3:0] digit_o,
  output logic       carry_o
);
  logic [3:0] dig_q;

  assign carry_o = inc_i && (dig_q == 4'd9);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dig_q <= 4'd0;
    else if (clr_i)   dig_q <= 4'd0;
    else if (carry_o) dig_q <= 4'd0;
    else if (inc_i)   dig_q <= dig_q + 4'd1;
  end

  assign digit_o = dig_q;
endmodule

// File: rtl/bcd_ms_counter.sv
module bcd_ms_counter #(
  parameter int unsigned CLK_DIV    = 32,
  parameter int unsigned NUM_DIGITS = 3   // at least 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              mode_i,
  input  logic                    sw_run_i,
  input  logic                    meas_pin_i,
  input  logic                    clear_i,
  input  logic                    irq_sel_i,
  output logic [4*NUM_DIGITS-1:0] digits_o,
  output logic                    running_o,
  output logic                    irq_o
);
  logic run, start_clr, clr_all, tick, irq_q;
  logic [NUM_DIGITS:0]   inc;
  logic [NUM_DIGITS-1:0] carry;

  bcd_ms_run_ctrl u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .sw_run_i    (sw_run_i),
    .pin_i       (meas_pin_i),
    .run_o       (run),
    .start_clr_o (start_clr)
  );

  assign clr_all = clear_i || start_clr;

  bcd_ms_prescaler #(.CLK_DIV(CLK_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (clr_all),
    .tick_o (tick)
  );

  assign inc[0] = tick;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    bcd_ms_digit u_dig (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_all),
      .inc_i   (inc[g]),
      .digit_o (digits_o[4*g +: 4]),
      .carry_o (carry[g])
    );
    assign inc[g+1] = carry[g];
  end

  // Tenth-second mark is the carry out of the tens digit.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= !clr_all && (irq_sel_i ? carry[NUM_DIGITS-1] : carry[1]);
  end

  assign running_o = run;
  assign irq_o     = irq_q;
endmodule

// File: rtl/bcd_ms_counter_chk.sv
module bcd_ms_counter_chk
  import bcd_ms_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  mode_i,
  input logic        sw_run_i,
  input logic        meas_pin_i,
  input logic        clear_i,
  input logic [11:0] digits_o,
  input logic        running_o,
  input logic        irq_o
);
  p_bcd_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digits_o[3:0] <= 4'd9) && (digits_o[7:4] <= 4'd9) && (digits_o[11:8] <= 4'd9));

  p_sw_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SW) |=> (running_o == $past(sw_run_i)));

  p_width_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_WIDTH) |=> (running_o == $past(meas_pin_i)));

  p_off_stopped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |=> !running_o);

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (digits_o == 12'h000) && !irq_o);

  p_irq_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_at_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (digits_o[7:0] == 8'h00));

  p_hold_stopped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !clear_i && mode_i != MODE_PERIOD) |=> $stable(digits_o));
endmodule

bind bcd_ms_counter bcd_ms_counter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .sw_run_i   (sw_run_i),
  .meas_pin_i (meas_pin_i),
  .clear_i    (clear_i),
  .digits_o   (digits_o),
  .running_o  (running_o),
  .irq_o      (irq_o)
);

// File: tb/bcd_ms_counter_tb.sv
module bcd_ms_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 32;
  localparam int WDOG       = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic sw_run = 1'b0, pin = 1'b0, clr = 1'b0, sel = 1'b0;
  logic [11:0] digits;
  logic running, irq;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  bcd_ms_counter #(.CLK_DIV(DIV), .NUM_DIGITS(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sw_run_i(sw_run),
    .meas_pin_i(pin), .clear_i(clr), .irq_sel_i(sel),
    .digits_o(digits), .running_o(running), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: count in milliseconds, as an integer.
  int m_ms = 0, m_div = 0;
  bit m_run = 0, m_pin = 0, m_irq = 0;
  int m_mode = 0;

  function automatic logic [11:0] to_bcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ms = 0; m_div = 0; m_run = 0; m_pin = 0; m_irq = 0; m_mode = 0;
    end else begin
      bit rise, sclr, tick, nrun;
      rise = pin && !m_pin;
      sclr = clr || (mode == 2'd2 && rise && !m_run);
      tick = m_run && (m_div == DIV - 1);
      case (mode)
        2'd0: nrun = sw_run;
        2'd1: nrun = pin;
        2'd2: nrun = rise ? !m_run : m_run;
        default: nrun = 0;
      endcase
      m_irq = !sclr && tick && (sel ? (m_ms == 999) : (m_ms % 100 == 99));
      if (sclr || !m_run || tick) m_div = 0; else m_div = m_div + 1;
      if (sclr) m_ms = 0; else if (tick) m_ms = (m_ms + 1) % 1000;
      m_run = nrun; m_pin = pin; m_mode = int'(mode);
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      chk(digits[3:0] <= 9 && digits[7:4] <= 9 && digits[11:8] <= 9, "R1 digit range", digits, 9);
      chk(digits == to_bcd(m_ms), "R2 count", digits, to_bcd(m_ms));
      chk(running == m_run, m_mode == 0 ? "R4 run" : m_mode == 1 ? "R5 run" : "R6 run", running, m_run);
      chk(irq == m_irq, sel ? "R9 irq" : "R8 irq", irq, m_irq);
      if (cyc > WDOG) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic clk_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1bcd));
    #(CLK_PERIOD*3 + 2);
    // R10: reset state
    chk(digits == 12'h000 && !running && !irq, "R10 reset", {digits, running, irq}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3/R4: software run for 12 ms + 10 cycles -> 012, carry 9 to 10
    clk_n(2);
    sw_run = 1'b1;
    repeat (DIV*12 + 10) @(posedge clk);
    @(negedge clk); sw_run = 1'b0;
    clk_n(2);
    chk(digits == 12'h012, "R3 carry/R2 rate", digits, 12'h012);
    // R11: hold while stopped
    clk_n(100);
    chk(digits == 12'h012, "R11 hold", digits, 12'h012);
    // R7: clear
    clr = 1'b1; clk_n(1); clr = 1'b0;
    chk(digits == 12'h000, "R7 clear", digits, 0);

    // R5: pulse width 3 ms + 31 cycles -> 003
    mode = 2'd1; clk_n(3);
    pin = 1'b1;
    repeat (DIV*3 + 31) @(posedge clk);
    @(negedge clk); pin = 1'b0;
    clk_n(3);
    chk(digits == 12'h003 && !running, "R5 width", digits, 12'h003);

    // R6: period of 7 ms + 5 cycles -> 007 (starts from zero)
    mode = 2'd2; clk_n(2);
    pin = 1'b1; clk_n(20); pin = 1'b0;
    clk_n(DIV*7 + 5 - 20 - 1);
    pin = 1'b1; clk_n(1);
    chk(!running, "R6 stop", running, 0);
    pin = 1'b0; clk_n(40);
    chk(digits == 12'h007, "R6 period", digits, 12'h007);
    // R6: mode 3 stops
    mode = 2'd3; clk_n(2);
    chk(!running, "R6 off", running, 0);

    // R8: tenth-second interrupt at 100
    mode = 2'd0; sel = 1'b0;
    clr = 1'b1; clk_n(1); clr = 1'b0;
    sw_run = 1'b1;
    for (int i = 0; i < DIV*101 && !irq; i++) clk_n(1);
    chk(irq && digits == 12'h100, "R8 tenth irq", digits, 12'h100);

    // R9: one-second interrupt only at 999 -> 000
    sw_run = 1'b0; sel = 1'b1; clk_n(2);
    clr = 1'b1; clk_n(1); clr = 1'b0;
    sw_run = 1'b1;
    for (int i = 0; i < DIV*1002 && !irq; i++) clk_n(1);
    chk(irq && digits == 12'h000, "R9 second irq/R3 wrap", digits, 0);
    sw_run = 1'b0; clk_n(2);

    // Random mix
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ($urandom_range(1999) == 0) mode = 2'($urandom_range(3));
      if ($urandom_range(299) == 0) sw_run = !sw_run;
      if ($urandom_range(149) == 0) pin = !pin;
      clr = ($urandom_range(1499) == 0);
      if ($urandom_range(2999) == 0) sel = !sel;
    end
    clr = 1'b0;
    clk_n(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule